// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matching Scheduler

This block decides, for an N-port input-queued crossbar, which input may send to which output in the next transfer slot. Each input keeps one queue per output; a request matrix tells the scheduler which of those queues hold data. The scheduler returns a conflict-free matching. In that matching each input is paired with at most one output, and each output with at most one input.

A round begins when `start_i` is seen while the block is idle. The request matrix and the iteration count are captured at that point. The block then runs a fixed number of iterations, and each iteration takes two clock cycles. The first cycle is the grant cycle: every still-free output picks one requesting free input. The second cycle is the accept cycle: every input that received grants keeps one of them. Round-robin pointers that persist across rounds spread service fairly. When the round ends, `done_o` pulses for one cycle. The matching and a count of productive iterations are then held on the outputs until the next `done_o`.

Top module: `islip_sched`

## Requirements
- R1: After reset, `match_o`, `iter_used_o`, `done_o` and `busy_o` are 0, and every grant and accept pointer is 0. The first round with all requests set and one iteration therefore matches only input 0 to output 0.
- R2: The request matrix and the iteration count are sampled only on a clock edge where `start_i` is high and `busy_o` is low. `start_i` and `req_i` are ignored while a round runs.
- R3: In each grant cycle, every unmatched output grants one unmatched input that requests it. The output picks the first such input found by searching upward from its grant pointer, wrapping past N-1 to 0.
- R4: In each accept cycle, every input holding grants accepts the first granting output found by searching upward from its accept pointer, with the same wrap.
- R5: Pointers move only on an accepted grant. The output's grant pointer becomes (input+1) mod N, and the input's accept pointer becomes (output+1) mod N. This happens in any iteration. A grant that is not accepted leaves both pointers unchanged.
- R6: Inputs and outputs matched in an earlier iteration take no part in later iterations of the same round. Every row and every column of the result holds at most one set bit.
- R7: `iter_cfg_i` holds the iteration count minus one, so the range is 1 to 4. If `start_i` is taken at edge e, `done_o` is high in the cycle after edge e+2K, where K is the iteration count.
- R8: Bit i*N+j of `req_i` and of `match_o` refers to input i and output j. `match_o` changes only together with `done_o` and is held stable otherwise. It only contains pairs that were requested.
- R9: `iter_used_o` gives the number of iterations in the round that formed at least one new match. It is updated together with `done_o`.
- R10: `done_o` is high for exactly one cycle per round. `busy_o` is high from the cycle after the start edge up to, but not including, the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a round when idle |
| req_i | input | N_PORTS*N_PORTS | Non-empty queue flags, bit i*N+j = input i to output j |
| iter_cfg_i | input | $clog2(MAX_ITER) | Iteration count minus one |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | One-cycle end-of-round strobe |
| match_o | output | N_PORTS*N_PORTS | Held matching, one-hot per input row |
| iter_used_o | output | $clog2(MAX_ITER+1) | Iterations that produced new matches |

## Verification
The assertions rest on one assumption about the environment: a new round is only requested on edges where `busy_o` is low. Under that assumption, the captured request matrix stays constant for a whole round, and the held result changes only at the strobe. The stimulus launches each round only after it has seen `busy_o` low. It also deliberately raises `start_i` and flips `req_i` in the middle of a round, and then checks that the result still reflects the captured matrix. A reference model with its own pointer state predicts every matching across full, sparse, contended, empty and random matrices with every iteration count.

// File: rtl/islip_pkg.sv
package islip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GRANT  = 2'd1,
    ST_ACCEPT = 2'd2
  } sched_st_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] ptr_i,
  output logic [N-1:0] gnt_o
);
  logic found;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int k;
      k = int'(ptr_i) + off;
      if (k >= N) k = k - N;
      if (!found && req_i[k]) begin
        gnt_o[k] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/islip_fsm.sv
module islip_fsm
  import islip_pkg::*;
#(
  parameter int ITER_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ITER_W-1:0] iter_cfg_i,
  output logic              load_o,
  output logic              grant_o,
  output logic              accept_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);
  sched_st_e         st_q;
  logic [ITER_W-1:0] iter_q, lim_q;

  assign load_o   = (st_q == ST_IDLE) && start_i;
  assign grant_o  = (st_q == ST_GRANT);
  assign accept_o = (st_q == ST_ACCEPT);
  assign last_o   = accept_o && (iter_q == lim_q);
  assign busy_o   = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      lim_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          lim_q  <= iter_cfg_i;
          iter_q <= '0;
          st_q   <= ST_GRANT;
        end
        ST_GRANT: st_q <= ST_ACCEPT;
        ST_ACCEPT: begin
          if (iter_q == lim_q) st_q <= ST_IDLE;
          else begin
            iter_q <= iter_q + 1'b1;
            st_q   <= ST_GRANT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R7
  grant_then_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> accept_o);
endmodule

// File: rtl/islip_sched.sv
module islip_sched #(
  parameter int N_PORTS  = 4,
  parameter int MAX_ITER = 4,
  localparam int NN     = N_PORTS * N_PORTS,
  localparam int PTR_W  = $clog2(N_PORTS),
  localparam int ITER_W = $clog2(MAX_ITER),
  localparam int CNT_W  = $clog2(MAX_ITER + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NN-1:0]     req_i,
  input  logic [ITER_W-1:0] iter_cfg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [NN-1:0]     match_o,
  output logic [CNT_W-1:0]  iter_used_o
);
  // [i][j]: input i, output j
  logic [N_PORTS-1:0][N_PORTS-1:0] req_q, gnt_q, gnt_d, match_q, acc;
  // [j][i]: output j view
  logic [N_PORTS-1:0][N_PORTS-1:0] rcol, gcol;
  logic [N_PORTS-1:0][PTR_W-1:0]   gptr_q, aptr_q, gptr_d, aptr_d;
  logic [N_PORTS-1:0]              in_m_q, out_m_q, in_m_d, out_m_d;
  logic [CNT_W-1:0]                used_q;
  logic                            any_acc;
  logic load, grant_ph, accept_ph, last;

  islip_fsm #(.ITER_W(ITER_W)) u_fsm (
    .clk_i, .rst_ni, .start_i, .iter_cfg_i,
    .load_o(load), .grant_o(grant_ph), .accept_o(accept_ph),
    .last_o(last), .busy_o, .done_o
  );

  always_comb begin
    for (int j = 0; j < N_PORTS; j++)
      for (int i = 0; i < N_PORTS; i++) begin
        rcol[j][i]  = req_q[i][j] & ~in_m_q[i] & ~out_m_q[j];
        gnt_d[i][j] = gcol[j][i];
      end
  end

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out
    rr_pick #(.N(N_PORTS)) u_gnt (
      .req_i(rcol[j]), .ptr_i(gptr_q[j]), .gnt_o(gcol[j])
    );
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    rr_pick #(.N(N_PORTS)) u_acc (
      .req_i(gnt_q[i]), .ptr_i(aptr_q[i]), .gnt_o(acc[i])
    );
  end

  always_comb begin
    gptr_d  = gptr_q;
    aptr_d  = aptr_q;
    in_m_d  = in_m_q;
    out_m_d = out_m_q;
    any_acc = 1'b0;
    for (int i = 0; i < N_PORTS; i++)
      for (int j = 0; j < N_PORTS; j++)
        if (acc[i][j]) begin
          any_acc    = 1'b1;
          in_m_d[i]  = 1'b1;
          out_m_d[j] = 1'b1;
          gptr_d[j]  = (i == N_PORTS - 1) ? '0 : PTR_W'(i + 1);
          aptr_d[i]  = (j == N_PORTS - 1) ? '0 : PTR_W'(j + 1);
        end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q       <= '0;
      gnt_q       <= '0;
      match_q     <= '0;
      in_m_q      <= '0;
      out_m_q     <= '0;
      gptr_q      <= '0;
      aptr_q      <= '0;
      used_q      <= '0;
      match_o     <= '0;
      iter_used_o <= '0;
    end else begin
      if (load) begin
        req_q   <= req_i;
        match_q <= '0;
        in_m_q  <= '0;
        out_m_q <= '0;
        used_q  <= '0;
      end
      if (grant_ph) gnt_q <= gnt_d;
      if (accept_ph) begin
        match_q <= match_q | acc;
        in_m_q  <= in_m_d;
        out_m_q <= out_m_d;
        gptr_q  <= gptr_d;
        aptr_q  <= aptr_d;
        used_q  <= used_q + CNT_W'(any_acc);
      end
      if (last) begin
        match_o     <= match_q | acc;
        iter_used_o <= used_q + CNT_W'(any_acc);
      end
    end
  end

  logic [N_PORTS-1:0][N_PORTS-1:0] mcol;
  always_comb
    for (int j = 0; j < N_PORTS; j++)
      for (int i = 0; i < N_PORTS; i++) mcol[j][i] = match_o[i*N_PORTS + j];

  for (genvar k = 0; k < N_PORTS; k++) begin : g_chk
    // R6
    row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(match_o[k*N_PORTS +: N_PORTS]));
    // R6
    col_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(mcol[k]));
    // R4
    accept_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept_ph |-> $onehot0(acc[k]));
  end

  // R3
  grant_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_ph |=> ((gnt_q & ~req_q) == '0));
  // R5
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_ph |=> ($stable(gptr_q) && $stable(aptr_q)));
  // R8
  match_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(match_o));
  // R8
  match_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((match_o & ~NN'(req_q)) == '0));
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$rose(busy_o)) |-> $stable(req_q));
  // R9
  used_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(iter_used_o) <= MAX_ITER));
endmodule

// File: tb/sim_islip_sched.sv
module sim_islip_sched;
  localparam int N = 4;
  localparam int NN = N * N;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [NN-1:0] req_i = '0;
  logic [1:0] iter_cfg_i = '0;
  logic busy_o, done_o;
  logic [NN-1:0] match_o;
  logic [2:0] iter_used_o;

  islip_sched #(.N_PORTS(N), .MAX_ITER(4)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .req_i, .iter_cfg_i,
    .busy_o, .done_o, .match_o, .iter_used_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  typedef struct { logic [NN-1:0] m; int used; int dcyc; } exp_t;
  exp_t sb[$];
  int gp[N], ap[N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: round-robin request/grant/accept with persistent pointers
  task automatic model(input logic [NN-1:0] r, input int k,
                       output logic [NN-1:0] m, output int used);
    bit im[N], om[N];
    m = '0; used = 0;
    for (int i = 0; i < N; i++) begin im[i] = 0; om[i] = 0; end
    for (int it = 0; it < k; it++) begin
      logic [NN-1:0] g;
      bit newm;
      g = '0; newm = 0;
      for (int j = 0; j < N; j++) begin
        bit f;
        f = 0;
        if (!om[j])
          for (int off = 0; off < N; off++) begin
            int i;
            i = (gp[j] + off) % N;
            if (!f && r[i*N+j] && !im[i]) begin g[i*N+j] = 1'b1; f = 1; end
          end
      end
      for (int i = 0; i < N; i++) begin
        bit f;
        f = 0;
        for (int off = 0; off < N; off++) begin
          int j;
          j = (ap[i] + off) % N;
          if (!f && g[i*N+j]) begin
            f = 1; newm = 1;
            m[i*N+j] = 1'b1; im[i] = 1; om[j] = 1;
            gp[j] = (i + 1) % N; ap[i] = (j + 1) % N;
          end
        end
      end
      used += int'(newm);
    end
  endtask

  task automatic run_round(input logic [NN-1:0] r, input int k, input bit noise);
    exp_t e;
    int u;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    model(r, k, e.m, u);
    e.used = u;
    req_i = r; iter_cfg_i = 2'(k - 1); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    e.dcyc = cyc + 2 * k;
    sb.push_back(e);
    if (noise) begin
      // R2: start and request change mid-round must be ignored
      start_i = 1'b1; req_i = ~r;
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  logic [NN-1:0] last_m = '0;
  bit prev_done = 0;
  initial forever begin
    @(negedge clk);
    if (rst_ni) begin
      if (done_o) begin
        if (sb.size() == 0) chk(0, "R10 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          // R3 R4 R5 R6 checked through the matching
          chk(match_o == e.m, "R8 match", int'(match_o), int'(e.m));
          chk(int'(iter_used_o) == e.used, "R9 used", int'(iter_used_o), e.used);
          chk(cyc == e.dcyc, "R7 latency", cyc, e.dcyc);
        end
        chk(!busy_o, "R10 busy at done", int'(busy_o), 0);
        chk(!prev_done, "R10 pulse", int'(prev_done), 0);
        last_m = match_o;
      end else
        chk(match_o == last_m, "R8 hold", int'(match_o), int'(last_m));
      prev_done = done_o;
    end
  end

  initial begin
    repeat (1000000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin gp[i] = 0; ap[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(match_o == '0, "R1 match", int'(match_o), 0);
    chk(!done_o && !busy_o, "R1 flags", int'({done_o, busy_o}), 0);
    chk(iter_used_o == '0, "R1 used", int'(iter_used_o), 0);
    rst_ni = 1'b1;
    // R1: zero pointers, full requests, one iteration -> only (0,0)
    run_round({NN{1'b1}}, 1, 0);
    // R5: pointer of output 0 now favours input 1
    run_round(16'h0011, 1, 0);
    // R3 R4: contention on one output, two iterations
    run_round(16'h1111, 2, 0);
    // R6: full matrix, four iterations gives full permutation
    run_round({NN{1'b1}}, 4, 0);
    // R9: empty matrix
    run_round('0, 3, 0);
    // R2: noise during round
    run_round(16'h8421, 2, 1);
    run_round(16'h00F0, 3, 1);
    for (int n = 0; n < 60; n++)
      run_round(NN'($urandom), int'($urandom_range(4, 1)), (n % 5) == 0);
    while (sb.size() != 0 || busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R10 all done", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule